// File: doc/BRIEF.md
# Nonvolatile Command Sequence Detector

This block sits beside a parallel memory's bus interface and watches the stream of completed bus cycles. Software issues nonvolatile commands through ordinary reads: five reads of fixed unlock addresses, in a fixed order, arm the detector. A sixth read then selects the command by its address. The four commands are store, recall, automatic-store disable and automatic-store enable. Each command is reported as a one-cycle pulse. Store and recall also hold a busy output for a set number of clock cycles, which stands in for the nonvolatile transfer time. While busy is high the block takes no notice of the bus.

The block keeps a dirty flag. Any completed write sets it, and the end of a store or recall clears it. Store requests from the automatic (power-loss) path and from the hardware store pin are acted on only when the flag is set, so an unchanged array is never stored again. The automatic path also needs automatic store to be enabled. A software store is always carried out.

Top module: `nvcmd_seq_detect`

## Requirements
- R1: After reset, busy, dirty and all four command pulses are low, and automatic store is enabled.
- R2: A bus cycle counts only in a clock cycle where `cyc_done` is high. It is a valid read when `bus_cs_n`=0, `bus_we_n`=1 and `bus_oe_n`=0. It is a write when `bus_cs_n`=0 and `bus_we_n`=0. Any other cycle (deselected, or selected with both strobes high) leaves the detector's progress unchanged.
- R3: Valid reads of 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, in that order, followed by a valid read of `STORE_ADDR` raise `store_pulse` for exactly one cycle, starting in the cycle after the clock edge that samples the sixth read. `busy` is high for exactly `STORE_CYC` cycles, starting in that same cycle.
- R4: The key followed by a read of `RECALL_ADDR` raises `recall_pulse` for one cycle with the same timing, and `busy` is then high for exactly `RECALL_CYC` cycles.
- R5: The key followed by a read of `AS_OFF_ADDR` (0x8B45 by default) raises `as_off_pulse` and disables automatic store. After that, `auto_store_req` starts nothing, even when dirty is set. The key followed by `AS_ON_ADDR` raises `as_on_pulse` and enables automatic store again. Neither command raises busy.
- R6: A valid read whose address is not the next expected key word returns the detector to idle, and so does any write. Finishing the rest of the sequence after that issues no command.
- R7: A sixth valid read whose address matches none of the four command addresses issues no command and returns the detector to idle.
- R8: A completed write sets `dirty` in the cycle after the clock edge that samples it.
- R9: `dirty` clears at the same clock edge at which `busy` falls at the end of a store or a recall.
- R10: A request on `hw_store_req`, or on `auto_store_req` while automatic store is enabled, starts a store (a `store_pulse` and `STORE_CYC` busy cycles) only when `dirty` is set and `busy` is low. Otherwise the request is ignored.
- R11: While `busy` is high, bus cycles and store requests are ignored. Writes do not set dirty, and key reads do not advance the detector.
- R12: If a hardware or automatic store is granted in the same cycle that a software store or recall completes, only the store runs and the software command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | ADDR_W | Bus address of the current cycle |
| cyc_done | input | 1 | High for one clock when a bus cycle completes |
| hw_store_req | input | 1 | Hardware store request |
| auto_store_req | input | 1 | Automatic (power-loss) store request |
| store_pulse | output | 1 | One-cycle pulse when a store starts |
| recall_pulse | output | 1 | One-cycle pulse when a recall starts |
| as_off_pulse | output | 1 | One-cycle pulse on automatic-store disable |
| as_on_pulse | output | 1 | One-cycle pulse on automatic-store enable |
| busy | output | 1 | High while a store or recall runs |
| dirty | output | 1 | A write has completed since the last store or recall |

## Verification
The bench goes after sequences broken part way through, either by a wrong read or by a write. A matcher that restarted or held its position instead of going idle would then issue a command from an incomplete key. The bench puts deselected and strobe-less cycles inside a key, which a decoder treating every strobe as a step would break. It issues writes and key reads during busy, so a design that did not block the bus would pick up a dirty flag or a half-entered key. It also checks that store requests are refused when the array is clean, that automatic requests are refused while disabled, and that the hardware store wins when it meets a software recall in the same cycle. A design that granted both there would start two operations at once.

// File: rtl/nvcmd_pkg.sv
`timescale 1ns/1ps
package nvcmd_pkg;

  localparam int KEY_W   = 16;
  localparam int KEY_LEN = 5;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_STORE,
    CMD_RECALL,
    CMD_AS_OFF,
    CMD_AS_ON
  } nv_cmd_e;

  // Unlock word expected at each step of the key
  function automatic logic [KEY_W-1:0] key_word(input int idx);
    logic [KEY_W-1:0] w;
    case (idx)
      0:       w = 16'h4E38;
      1:       w = 16'hB1C7;
      2:       w = 16'h83E0;
      3:       w = 16'h7C1F;
      4:       w = 16'h703F;
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic bus_is_read(input logic cs_n, input logic oe_n, input logic we_n);
    return !cs_n && we_n && !oe_n;
  endfunction

  function automatic logic bus_is_write(input logic cs_n, input logic we_n);
    return !cs_n && !we_n;
  endfunction

endpackage

// File: rtl/nvcmd_bus_decode.sv
`timescale 1ns/1ps
module nvcmd_bus_decode
  import nvcmd_pkg::*;
(
  input  logic cyc_done,
  input  logic cs_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic hold,
  output logic rd_ev,
  output logic wr_ev
);

  // Completed cycles only, and nothing at all while an operation runs
  assign rd_ev = cyc_done && !hold && bus_is_read(cs_n, oe_n, we_n);
  assign wr_ev = cyc_done && !hold && bus_is_write(cs_n, we_n);

endmodule

// File: rtl/nvcmd_key_match.sv
`timescale 1ns/1ps
module nvcmd_key_match
  import nvcmd_pkg::*;
#(
  parameter int               ADDR_W      = 16,
  parameter logic [KEY_W-1:0] STORE_ADDR  = 16'h8FC0,
  parameter logic [KEY_W-1:0] RECALL_ADDR = 16'h4C63,
  parameter logic [KEY_W-1:0] AS_OFF_ADDR = 16'h8B45,
  parameter logic [KEY_W-1:0] AS_ON_ADDR  = 16'h4B46,
  localparam int              STEP_W      = $clog2(KEY_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_ev,
  input  logic              wr_ev,
  input  logic [ADDR_W-1:0] addr,
  output nv_cmd_e           cmd_o,
  output logic [STEP_W-1:0] step_o
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(KEY_LEN);

  logic [STEP_W-1:0] step_q;
  logic [KEY_LEN-1:0] key_hit;
  logic [KEY_W-1:0]   a16;
  logic               exp_hit;
  logic               at_cmd;

  assign a16 = addr[KEY_W-1:0];

  generate
    for (genvar i = 0; i < KEY_LEN; i++) begin : g_key
      assign key_hit[i] = (a16 == key_word(i));
    end
  endgenerate

  assign at_cmd  = (step_q == LAST_STEP);
  assign exp_hit = !at_cmd && key_hit[step_q];

  always_comb begin
    cmd_o = CMD_NONE;
    if (rd_ev && at_cmd) begin
      if (a16 == STORE_ADDR)       cmd_o = CMD_STORE;
      else if (a16 == RECALL_ADDR) cmd_o = CMD_RECALL;
      else if (a16 == AS_OFF_ADDR) cmd_o = CMD_AS_OFF;
      else if (a16 == AS_ON_ADDR)  cmd_o = CMD_AS_ON;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (wr_ev) begin
      step_q <= '0;
    end else if (rd_ev) begin
      if (exp_hit) step_q <= step_q + 1'b1;
      else         step_q <= '0;
    end
  end

  assign step_o = step_q;

endmodule

// File: rtl/nvcmd_op_timer.sv
`timescale 1ns/1ps
module nvcmd_op_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= len;
    else if (busy)  cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/nvcmd_seq_detect.sv
`timescale 1ns/1ps
module nvcmd_seq_detect
  import nvcmd_pkg::*;
#(
  parameter int               ADDR_W      = 16,
  parameter int               STORE_CYC   = 20,
  parameter int               RECALL_CYC  = 40,
  parameter logic [KEY_W-1:0] STORE_ADDR  = 16'h8FC0,
  parameter logic [KEY_W-1:0] RECALL_ADDR = 16'h4C63,
  parameter logic [KEY_W-1:0] AS_OFF_ADDR = 16'h8B45,
  parameter logic [KEY_W-1:0] AS_ON_ADDR  = 16'h4B46
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              cyc_done,
  input  logic              hw_store_req,
  input  logic              auto_store_req,
  output logic              store_pulse,
  output logic              recall_pulse,
  output logic              as_off_pulse,
  output logic              as_on_pulse,
  output logic              busy,
  output logic              dirty
);

  localparam int MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int STEP_W  = $clog2(KEY_LEN + 1);

  // Named internal events
  logic              rd_ev, wr_ev;
  nv_cmd_e           sw_cmd;
  logic [STEP_W-1:0] step_w;
  logic              op_busy, op_done;
  logic              hw_go, au_go, start_store, start_recall, start_any;
  logic [CNT_W-1:0]  op_len;

  logic dirty_q, as_en_q;
  logic store_q, recall_q, off_q, on_q;

  nvcmd_bus_decode u_dec (
    .cyc_done (cyc_done),
    .cs_n     (bus_cs_n),
    .oe_n     (bus_oe_n),
    .we_n     (bus_we_n),
    .hold     (op_busy),
    .rd_ev    (rd_ev),
    .wr_ev    (wr_ev)
  );

  nvcmd_key_match #(
    .ADDR_W      (ADDR_W),
    .STORE_ADDR  (STORE_ADDR),
    .RECALL_ADDR (RECALL_ADDR),
    .AS_OFF_ADDR (AS_OFF_ADDR),
    .AS_ON_ADDR  (AS_ON_ADDR)
  ) u_match (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_ev  (rd_ev),
    .wr_ev  (wr_ev),
    .addr   (bus_addr),
    .cmd_o  (sw_cmd),
    .step_o (step_w)
  );

  // Store requests from the hardware pin and the power-loss path
  assign hw_go = hw_store_req && dirty_q && !op_busy;
  assign au_go = auto_store_req && as_en_q && dirty_q && !op_busy;

  // Hardware and automatic stores take priority over a software store or recall
  assign start_store  = hw_go || au_go || (sw_cmd == CMD_STORE);
  assign start_recall = !(hw_go || au_go) && (sw_cmd == CMD_RECALL);
  assign start_any    = start_store || start_recall;
  assign op_len       = start_recall ? CNT_W'(RECALL_CYC) : CNT_W'(STORE_CYC);

  nvcmd_op_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_any),
    .len   (op_len),
    .busy  (op_busy),
    .done  (op_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q <= 1'b0;
      as_en_q <= 1'b1;
    end else begin
      if (wr_ev)        dirty_q <= 1'b1;
      else if (op_done) dirty_q <= 1'b0;
      if (sw_cmd == CMD_AS_OFF)     as_en_q <= 1'b0;
      else if (sw_cmd == CMD_AS_ON) as_en_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q  <= 1'b0;
      recall_q <= 1'b0;
      off_q    <= 1'b0;
      on_q     <= 1'b0;
    end else begin
      store_q  <= start_store;
      recall_q <= start_recall;
      off_q    <= (sw_cmd == CMD_AS_OFF);
      on_q     <= (sw_cmd == CMD_AS_ON);
    end
  end

  assign store_pulse  = store_q;
  assign recall_pulse = recall_q;
  assign as_off_pulse = off_q;
  assign as_on_pulse  = on_q;
  assign busy         = op_busy;
  assign dirty        = dirty_q;

endmodule

// File: rtl/nvcmd_seq_detect_chk.sv
`timescale 1ns/1ps
module nvcmd_seq_detect_chk
  import nvcmd_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_ev,
  input logic              wr_ev,
  input logic [STEP_W-1:0] step,
  input nv_cmd_e           sw_cmd,
  input logic              busy,
  input logic              op_done,
  input logic              dirty,
  input logic              hw_req,
  input logic              au_req,
  input logic              store_p,
  input logic              recall_p,
  input logic              off_p,
  input logic              on_p
);

  // R3 / R4: only one of store and recall starts at a time
  p_one_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_p, recall_p}));

  // R3: a store pulse comes with busy and lasts one cycle
  p_store_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    store_p |-> busy);
  p_store_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    store_p |=> !store_p);

  // R5: the two automatic-store commands never pulse together
  p_as_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({off_p, on_p}));

  // R6: a write sends the detector back to idle
  p_write_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> (step == '0));

  // R6: step never passes the command position
  p_step_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step <= STEP_W'(KEY_LEN));

  // R8: a write sets dirty
  p_dirty_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> dirty);

  // R9: completion clears dirty together with busy
  p_dirty_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> (!dirty && !busy));

  // R10: a clean array refuses store requests
  p_suppress_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_req || au_req) && !dirty && !busy && sw_cmd != CMD_STORE) |=> !store_p);

  // R11: no bus event is accepted during busy
  p_quiet_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!rd_ev && !wr_ev));

  // R12: a granted hardware store wins over a software recall
  p_priority_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_req && dirty && !busy) |=> (store_p && !recall_p));

endmodule

bind nvcmd_seq_detect nvcmd_seq_detect_chk #(.STEP_W(STEP_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_ev    (rd_ev),
  .wr_ev    (wr_ev),
  .step     (step_w),
  .sw_cmd   (sw_cmd),
  .busy     (op_busy),
  .op_done  (op_done),
  .dirty    (dirty_q),
  .hw_req   (hw_store_req),
  .au_req   (auto_store_req),
  .store_p  (store_q),
  .recall_p (recall_q),
  .off_p    (off_q),
  .on_p     (on_q)
);

// File: tb/nvcmd_seq_detect_tb.sv
`timescale 1ns/1ps
module nvcmd_seq_detect_tb_top;

  localparam int          T_STORE  = 12;
  localparam int          T_RECALL = 25;
  localparam logic [15:0] A_STORE  = 16'h8FC0;
  localparam logic [15:0] A_RECALL = 16'h4C63;
  localparam logic [15:0] A_OFF    = 16'h8B45;
  localparam logic [15:0] A_ON     = 16'h4B46;
  localparam logic [15:0] KEYS [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, cyc_done = 1'b0;
  logic hw_req = 1'b0, au_req = 1'b0;
  logic [15:0] addr = '0;
  logic store_p, recall_p, off_p, on_p, busy, dirty;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  nvcmd_seq_detect #(
    .ADDR_W(16), .STORE_CYC(T_STORE), .RECALL_CYC(T_RECALL),
    .STORE_ADDR(A_STORE), .RECALL_ADDR(A_RECALL),
    .AS_OFF_ADDR(A_OFF), .AS_ON_ADDR(A_ON)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_addr(addr), .cyc_done(cyc_done), .hw_store_req(hw_req),
    .auto_store_req(au_req), .store_pulse(store_p), .recall_pulse(recall_p),
    .as_off_pulse(off_p), .as_on_pulse(on_p), .busy(busy), .dirty(dirty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One completed bus cycle; returns at the falling edge after the sampling edge
  task automatic cyc(input logic c, input logic o, input logic w, input logic [15:0] a,
                     input logic h, input logic u);
    @(negedge clk);
    cs_n = c; oe_n = o; we_n = w; addr = a; hw_req = h; au_req = u; cyc_done = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; hw_req = 1'b0; au_req = 1'b0; cyc_done = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);  cyc(1'b0, 1'b0, 1'b1, a, 1'b0, 1'b0); endtask
  task automatic wr(input logic [15:0] a);  cyc(1'b0, 1'b1, 1'b0, a, 1'b0, 1'b0); endtask
  task automatic req(input logic h, input logic u); cyc(1'b1, 1'b1, 1'b1, 16'h0, h, u); endtask

  task automatic send_key();
    for (int i = 0; i < 5; i++) rd(KEYS[i]);
  endtask

  // Counts busy cycles from now and the cycles in which a start pulse is seen
  task automatic busy_len(output int n, output int pulses);
    n = 0; pulses = 0;
    while (busy === 1'b1 && n < 1000) begin
      n++;
      if (store_p || recall_p) pulses++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 dirty", dirty, 0);
    chk("R1 pulses", {store_p, recall_p, off_p, on_p}, 0);
  endtask

  task automatic t_suppress();
    req(1'b1, 1'b0);
    chk("R10 clean hw store ignored", {store_p, busy}, 0);
    req(1'b0, 1'b1);
    chk("R10 clean auto store ignored", {store_p, busy}, 0);
  endtask

  task automatic t_store();
    int n, p;
    wr(16'h1234);
    chk("R8 write sets dirty", dirty, 1);
    send_key();
    rd(A_STORE);
    chk("R3 store pulse", {store_p, recall_p, off_p, on_p}, 4'b1000);
    busy_len(n, p);
    chk("R3 store busy length", n, T_STORE);
    chk("R3 single pulse", p, 1);
    chk("R9 dirty cleared by store", dirty, 0);
  endtask

  task automatic t_recall();
    int n, p;
    wr(16'h0042);
    send_key();
    rd(A_RECALL);
    chk("R4 recall pulse", {store_p, recall_p}, 2'b01);
    busy_len(n, p);
    chk("R4 recall busy length", n, T_RECALL);
    chk("R9 dirty cleared by recall", dirty, 0);
  endtask

  task automatic t_gaps();
    int n, p;
    rd(KEYS[0]); rd(KEYS[1]);
    cyc(1'b1, 1'b0, 1'b1, 16'h5555, 1'b0, 1'b0);   // deselected
    rd(KEYS[2]);
    cyc(1'b0, 1'b1, 1'b1, 16'h6666, 1'b0, 1'b0);   // no strobe
    rd(KEYS[3]); rd(KEYS[4]);
    rd(A_STORE);
    chk("R2 ignored cycles keep progress", store_p, 1);
    busy_len(n, p);
  endtask

  task automatic t_break();
    rd(KEYS[0]); rd(KEYS[1]); rd(KEYS[2]);
    rd(16'h0BAD);
    rd(KEYS[3]); rd(KEYS[4]); rd(A_STORE);
    chk("R6 wrong read breaks key", {store_p, busy}, 0);
    rd(KEYS[0]); rd(KEYS[1]);
    wr(16'h0777);
    rd(KEYS[2]); rd(KEYS[3]); rd(KEYS[4]); rd(A_RECALL);
    chk("R6 write breaks key", {recall_p, busy}, 0);
    send_key();
    rd(16'h1111);
    chk("R7 unknown command", {store_p, recall_p, off_p, on_p, busy}, 0);
    rd(A_STORE);
    chk("R7 idle after unknown command", {store_p, busy}, 0);
  endtask

  task automatic t_autostore();
    int n, p;
    send_key();
    rd(A_OFF);
    chk("R5 disable pulse", {off_p, on_p, busy}, 3'b100);
    wr(16'h0200);
    req(1'b0, 1'b1);
    chk("R5 auto store refused when disabled", {store_p, busy, dirty}, 3'b001);
    req(1'b1, 1'b0);
    chk("R10 hw store when dirty", store_p, 1);
    busy_len(n, p);
    chk("R10 hw store busy length", n, T_STORE);
    send_key();
    rd(A_ON);
    chk("R5 enable pulse", {off_p, on_p, busy}, 3'b010);
    wr(16'h0201);
    req(1'b0, 1'b1);
    chk("R5 auto store after enable", store_p, 1);
    busy_len(n, p);
    chk("R9 dirty cleared by auto store", dirty, 0);
  endtask

  task automatic t_busy_quiet();
    int n, p;
    wr(16'h0300);
    send_key();
    rd(A_RECALL);
    chk("R4 recall starts", recall_p, 1);
    wr(16'h0301);
    send_key();
    busy_len(n, p);
    chk("R11 write during busy ignored", dirty, 0);
    rd(A_STORE);
    chk("R11 key during busy ignored", {store_p, busy}, 0);
  endtask

  task automatic t_conflict();
    int n, p;
    wr(16'h0400);
    send_key();
    cyc(1'b0, 1'b0, 1'b1, A_RECALL, 1'b1, 1'b0);
    chk("R12 hw store wins over recall", {store_p, recall_p}, 2'b10);
    busy_len(n, p);
    chk("R12 store length used", n, T_STORE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_suppress();
    t_store();
    t_recall();
    t_gaps();
    t_break();
    t_autostore();
    t_busy_quiet();
    t_conflict();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule